// File: doc/BRIEF.md
# Pipelined burst synchronous SRAM

A cycle-accurate, synthesizable model of a single-cycle-deselect pipelined burst SRAM. Each word holds four byte lanes, and each lane carries an optional parity bit. Every input is sampled on the rising clock edge. An access starts when either of two address strobes is seen. The host-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the write enables.

Once an access has started, a two-bit burst counter produces the low two word-address bits for each later cycle. It follows either a wrapping increment or an XOR pattern, chosen by a pin at the start of the burst. A step input advances the counter. When the step input is idle, the current address is simply repeated.

Read data passes through an array stage and then an output register. It therefore appears after the second rising edge that follows the command. Output drive can be removed asynchronously by the output enable. A doze input blocks every access while it is high.

The bus has no back-pressure: every cycle's command is accepted. The output `rdata_oe` serves as the valid flag for `rdata`. The only way to stall a burst is to hold the step input idle.

Top module: `burst_sram`

## Requirements
- R1: While reset is low, and after it is released, `rdata_oe` is 0 until a read is issued.
- R2: A read registered at edge k shows the addressed word on `rdata`, with `rdata_oe`=1 (when `oe_n`=0), after edge k+1.
- R3: With `order_xor`=0 at the start, the low address bits on burst step n are (start + n) mod 4, and the upper bits stay fixed.
- R4: With `order_xor`=1 at the start, the low address bits on burst step n are start XOR n.
- R5: With `wr_lane_n`=0 and `wr_all_n`=1, lane i (bits i*9+8..i*9) is written only when `lane_sel_n[i]`=0; the other lanes keep their contents.
- R6: `wr_all_n`=0 writes all four lanes, whatever `wr_lane_n` and `lane_sel_n` hold.
- R7: The device is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. An effective strobe while not selected ends the burst and writes nothing, and `rdata_oe` is 0 after the next edge.
- R8: `start_host_n` is ignored while `sel_a_n`=1, so a running burst continues. A host-strobe access is always a read, even when write enables are asserted.
- R9: When both strobes are low with `sel_a_n`=0, the host strobe wins and the access is a read.
- R10: `oe_n`=1 forces `rdata_oe` to 0 within the same cycle, without a clock edge. Returning `oe_n` to 0 restores the registered drive state.
- R11: A cycle with `doze`=1 performs no read or write, and `rdata_oe` is 0 after the following edge. Burst position is held.
- R12: In a burst, with no strobe and `step_n`=1, the same address is accessed again. With `step_n`=0, the counter advances first.
- R13: A write cycle never drives data: `rdata_oe` is 0 after the edge that executes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | ADDR_W | Word address, captured on a strobe |
| order_xor | input | 1 | Burst order: 0 wrapping increment, 1 XOR pattern |
| start_host_n | input | 1 | Host-side address strobe, active low, read only |
| start_ctrl_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip select, active low; also qualifies the host strobe |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_lane_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| wdata | input | WORD_W | Write data, sampled with the command |
| doze | input | 1 | Standby; blocks every access |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | WORD_W | Registered read data |
| rdata_oe | output | 1 | Output drivers on (valid flag for rdata) |

## Verification
The hardest situations to reach are those where strobes, selects and burst state interact: a host strobe with `sel_a_n` high in the middle of a burst, both strobes at once, and a write command issued during doze. Directed sequences set these up first. Constrained random traffic then mixes partial selects, doze, both burst orders and random lane masks over thousands of cycles. A bench model predicts every cycle's drive state and read data, so any deviation in burst position shows up as wrong data.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic {
    ORD_WRAP = 1'b0,
    ORD_XOR  = 1'b1
  } burst_order_e;

  // decoded command for one cycle
  typedef struct packed {
    logic load;   // new access at the captured address
    logic cont;   // burst continues (no strobe)
    logic halt;   // deselect: end burst
    logic step;   // advance the burst counter
  } cmd_t;

  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] pos,
                                           input burst_order_e ord);
    return (ord == ORD_XOR) ? (start ^ pos) : (start + pos);
  endfunction

endpackage

// File: rtl/burst_sram_decode.sv
module burst_sram_decode
  import burst_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             start_host_n,
  input  logic             start_ctrl_n,
  input  logic             step_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             wr_all_n,
  input  logic             wr_lane_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             doze,
  input  logic             burst_act,
  output cmd_t             cmd,
  output logic [LANES-1:0] lane_we
);

  logic             selected;
  logic             host_go;
  logic             ctrl_go;
  logic [LANES-1:0] lane_req;

  assign selected = !sel_a_n && sel_b && !sel_c_n;
  assign host_go  = !start_host_n && !sel_a_n;
  assign ctrl_go  = !start_ctrl_n;
  assign lane_req = !wr_all_n  ? {LANES{1'b1}} :
                    !wr_lane_n ? ~lane_sel_n   : '0;

  always_comb begin
    cmd     = '0;
    lane_we = '0;
    if (doze) begin
      cmd = '0;
    end else if (host_go || ctrl_go) begin
      if (selected) begin
        cmd.load = 1'b1;
        if (!host_go) lane_we = lane_req;
      end else begin
        cmd.halt = 1'b1;
      end
    end else if (burst_act) begin
      cmd.cont = 1'b1;
      cmd.step = !step_n;
      lane_we  = lane_req;
    end
  end

endmodule

// File: rtl/burst_sram_seq.sv
module burst_sram_seq
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_t              cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              order_xor,
  output logic              burst_act,
  output logic [ADDR_W-1:0] word_addr
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] base_hi;
  logic [1:0]      base_lo;
  logic [1:0]      pos;
  burst_order_e    ord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_act <= 1'b0;
      base_hi   <= '0;
      base_lo   <= '0;
      pos       <= '0;
      ord       <= ORD_WRAP;
    end else if (cmd.load) begin
      burst_act <= 1'b1;
      base_hi   <= addr[ADDR_W-1:2];
      base_lo   <= addr[1:0];
      pos       <= '0;
      ord       <= burst_order_e'(order_xor);
    end else if (cmd.halt) begin
      burst_act <= 1'b0;
    end else if (cmd.cont && cmd.step) begin
      pos <= pos + 2'd1;
    end
  end

  assign word_addr = {base_hi, burst_low(base_lo, pos, ord)};

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_v,
  input  logic [LANES-1:0]  acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [WORD_W-1:0] acc_wd,
  output logic [WORD_W-1:0] rd_q,
  output logic              rd_drv
);

  logic acc_rd;
  assign acc_rd = acc_v && !(|acc_we);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (acc_v && acc_we[l]) bank[acc_addr] <= acc_wd[l*LANE_W +: LANE_W];
      if (acc_rd)             lane_q         <= bank[acc_addr];
    end

    assign rd_q[l*LANE_W +: LANE_W] = lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_drv <= 1'b0;
    else        rd_drv <= acc_rd;
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int LANES    = 4,
  parameter int PAR_BITS = 1,
  localparam int LANE_W  = 8 + PAR_BITS,
  localparam int WORD_W  = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              order_xor,
  input  logic              start_host_n,
  input  logic              start_ctrl_n,
  input  logic              step_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              wr_all_n,
  input  logic              wr_lane_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic [WORD_W-1:0] wdata,
  input  logic              doze,
  input  logic              oe_n,
  output logic [WORD_W-1:0] rdata,
  output logic              rdata_oe
);

  cmd_t              cmd;
  logic [LANES-1:0]  lane_we;
  logic              burst_act;
  logic [ADDR_W-1:0] word_addr;

  // access stage registers
  logic              s_v;
  logic [LANES-1:0]  s_we;
  logic [WORD_W-1:0] s_wd;
  logic              rd_drv;

  burst_sram_decode #(.LANES(LANES)) u_dec (
    .start_host_n (start_host_n),
    .start_ctrl_n (start_ctrl_n),
    .step_n       (step_n),
    .sel_a_n      (sel_a_n),
    .sel_b        (sel_b),
    .sel_c_n      (sel_c_n),
    .wr_all_n     (wr_all_n),
    .wr_lane_n    (wr_lane_n),
    .lane_sel_n   (lane_sel_n),
    .doze         (doze),
    .burst_act    (burst_act),
    .cmd          (cmd),
    .lane_we      (lane_we)
  );

  burst_sram_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .addr      (addr),
    .order_xor (order_xor),
    .burst_act (burst_act),
    .word_addr (word_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_v  <= 1'b0;
      s_we <= '0;
      s_wd <= '0;
    end else begin
      s_v  <= cmd.load || cmd.cont;
      s_we <= lane_we;
      s_wd <= wdata;
    end
  end

  burst_sram_array #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_v    (s_v),
    .acc_we   (s_we),
    .acc_addr (word_addr),
    .acc_wd   (s_wd),
    .rd_q     (rdata),
    .rd_drv   (rd_drv)
  );

  assign rdata_oe = rd_drv && !oe_n;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_host_n,
  input logic             start_ctrl_n,
  input logic             sel_a_n,
  input logic             sel_b,
  input logic             sel_c_n,
  input logic             wr_all_n,
  input logic             wr_lane_n,
  input logic [LANES-1:0] lane_sel_n,
  input logic             doze,
  input logic             oe_n,
  input logic             rdata_oe
);

  logic sel_ok, host_go, ctrl_go, wr_any;
  assign sel_ok  = !sel_a_n && sel_b && !sel_c_n;
  assign host_go = !start_host_n && !sel_a_n;
  assign ctrl_go = !start_ctrl_n;
  assign wr_any  = !wr_all_n || (!wr_lane_n && (lane_sel_n != {LANES{1'b1}}));

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_idle_in_reset_R1: assert (!rdata_oe) else $error("R1 drive during reset");
    end
  end

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!doze && sel_ok && (host_go || (ctrl_go && !wr_any))) |-> ##2 (oe_n || rdata_oe));

  assert_deselect_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!doze && (host_go || ctrl_go) && !sel_ok) |-> ##2 !rdata_oe);

  assert_host_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!doze && sel_ok && host_go && ctrl_go && !wr_all_n) |-> ##2 (oe_n || rdata_oe));

  assert_oe_async_R10: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_oe);

  assert_doze_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    doze |-> ##2 !rdata_oe);

  assert_write_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!doze && sel_ok && !host_go && ctrl_go && wr_any) |-> ##2 !rdata_oe);

endmodule

bind burst_sram burst_sram_chk #(.LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_host_n (start_host_n),
  .start_ctrl_n (start_ctrl_n),
  .sel_a_n      (sel_a_n),
  .sel_b        (sel_b),
  .sel_c_n      (sel_c_n),
  .wr_all_n     (wr_all_n),
  .wr_lane_n    (wr_lane_n),
  .lane_sel_n   (lane_sel_n),
  .doze         (doze),
  .oe_n         (oe_n),
  .rdata_oe     (rdata_oe)
);

// File: tb/burst_sram_tb_top.sv
module burst_sram_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int WW    = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic          order_xor, start_host_n, start_ctrl_n, step_n;
  logic          sel_a_n, sel_b, sel_c_n, wr_all_n, wr_lane_n;
  logic [3:0]    lane_sel_n;
  logic [WW-1:0] wdata;
  logic          doze, oe_n;
  logic [WW-1:0] rdata;
  logic          rdata_oe;

  burst_sram #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .order_xor(order_xor),
    .start_host_n(start_host_n), .start_ctrl_n(start_ctrl_n), .step_n(step_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .wr_all_n(wr_all_n), .wr_lane_n(wr_lane_n), .lane_sel_n(lane_sel_n),
    .wdata(wdata), .doze(doze), .oe_n(oe_n), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic [WW-1:0] mref [DEPTH];
  logic          m_act, m_v, m_ord;
  int            m_hi, m_lo, m_cnt;
  logic [3:0]    m_we;
  logic [WW-1:0] m_wd;
  logic          e_drv;
  logic [WW-1:0] e_dat;

  int    n_chk = 0, n_fail = 0;
  string cur = "R1";
  bit    done = 0;

  function automatic logic [WW-1:0] pat(int a, int salt);
    return WW'(a * 36'h0_1357_9BD + salt * 36'h3_0F0F_0F0F) ^ 36'hA_5A5A_5A5A;
  endfunction

  function automatic int m_addr();
    int lo;
    lo = m_ord ? (m_lo ^ m_cnt) : ((m_lo + m_cnt) % 4);
    return m_hi * 4 + lo;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic sel, hst, ctl;
    logic [3:0] lanes;
    int a;
    if (!rst_n) begin
      m_act = 0; m_v = 0; e_drv = 0;
      return;
    end
    if (m_v) begin
      a = m_addr();
      if (m_we != 0) begin
        for (int l = 0; l < 4; l++)
          if (m_we[l]) mref[a][l*9 +: 9] = m_wd[l*9 +: 9];
        e_drv = 0;
      end else begin
        e_dat = mref[a];
        e_drv = 1;
      end
    end else begin
      e_drv = 0;
    end
    sel   = !sel_a_n && sel_b && !sel_c_n;
    hst   = !start_host_n && !sel_a_n;
    ctl   = !start_ctrl_n;
    lanes = !wr_all_n ? 4'hF : (!wr_lane_n ? ~lane_sel_n : 4'h0);
    m_wd  = wdata;
    if (doze) m_v = 0;
    else if (hst || ctl) begin
      if (sel) begin
        m_act = 1; m_hi = int'(addr) / 4; m_lo = int'(addr) % 4; m_cnt = 0;
        m_ord = order_xor; m_v = 1; m_we = hst ? 4'h0 : lanes;
      end else begin
        m_act = 0; m_v = 0;
      end
    end else if (m_act) begin
      if (!step_n) m_cnt = (m_cnt + 1) % 4;
      m_v = 1; m_we = lanes;
    end else m_v = 0;
  endtask

  // one clock: model update at the edge, check just after it
  task automatic tick();
    logic exp_oe;
    @(posedge clk);
    model_edge();
    #1;
    exp_oe = e_drv && !oe_n;
    chk(cur, 64'(rdata_oe), 64'(exp_oe));
    if (exp_oe) chk(cur, 64'(rdata), 64'(e_dat));
    @(negedge clk);
  endtask

  task automatic idle();
    start_host_n = 1; start_ctrl_n = 1; step_n = 1;
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    wr_all_n = 1; wr_lane_n = 1; lane_sel_n = 4'hF;
    doze = 0; oe_n = 0; order_xor = 0;
  endtask

  task automatic deselect();
    idle(); start_ctrl_n = 0; sel_b = 0; tick();
  endtask

  task automatic start_read(int a, bit host, bit xo);
    idle(); addr = AW'(a); order_xor = xo;
    if (host) start_host_n = 0; else start_ctrl_n = 0;
    tick();
  endtask

  // read one word and compare against an independently computed value
  task automatic read_word(int a, logic [WW-1:0] exp, string req);
    start_read(a, 1, 0);
    deselect();
    chk(req, 64'(rdata), 64'(exp));
    idle(); tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all R) actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] v;
    void'($urandom(32'd4711));
    idle(); addr = '0; wdata = '0;
    @(negedge clk);
    cur = "R1";
    repeat (3) tick();
    chk("R1", 64'(rdata_oe), 64'd0);
    rst_n = 1;
    tick();
    chk("R1", 64'(rdata_oe), 64'd0);

    // fill memory with back-to-back global writes (R6, R13)
    cur = "R13";
    for (int a = 0; a < DEPTH; a++) begin
      idle(); start_ctrl_n = 0; addr = AW'(a); wr_all_n = 0; wdata = pat(a, 0);
      tick();
    end
    deselect();
    idle(); tick();

    cur = "R2";
    read_word(5, pat(5, 0), "R2");

    // wrapping burst from low bits 1: 1,2,3,0
    cur = "R3";
    start_read(9, 0, 0);
    for (int n = 1; n < 5; n++) begin
      idle(); step_n = 0; tick();
      chk("R3", 64'(rdata), 64'(pat(8 + ((1 + n - 1) % 4), 0)));
    end
    deselect();

    // XOR burst from low bits 1: 1,0,3,2
    cur = "R4";
    start_read(9, 0, 1);
    for (int n = 1; n < 5; n++) begin
      idle(); step_n = 0; tick();
      chk("R4", 64'(rdata), 64'(pat(8 + (1 ^ (n - 1)), 0)));
    end
    deselect();

    // suspend: same address repeated
    cur = "R12";
    start_read(22, 0, 0);
    idle(); tick();
    idle(); tick();
    chk("R12", 64'(rdata), 64'(pat(22, 0)));
    idle(); step_n = 0; tick();
    chk("R12", 64'(rdata), 64'(pat(22, 0)));
    idle(); tick();
    chk("R12", 64'(rdata), 64'(pat(23, 0)));
    deselect();

    // lane write: lanes 0 and 2 only
    cur = "R5";
    idle(); start_ctrl_n = 0; addr = 6'd30; wr_lane_n = 0; lane_sel_n = 4'b1010;
    wdata = pat(30, 7); tick();
    deselect();
    v = pat(30, 0);
    v[8:0] = pat(30, 7)[8:0]; v[26:18] = pat(30, 7)[26:18];
    read_word(30, v, "R5");

    // global write overrides lane controls
    cur = "R6";
    idle(); start_ctrl_n = 0; addr = 6'd31; wr_all_n = 0; wr_lane_n = 0;
    lane_sel_n = 4'hF; wdata = pat(31, 3); tick();
    deselect();
    read_word(31, pat(31, 3), "R6");

    // write while one select is off: nothing written, burst ends
    cur = "R7";
    idle(); start_ctrl_n = 0; addr = 6'd33; sel_c_n = 1; wr_all_n = 0; wdata = pat(33, 9);
    tick();
    idle(); tick();
    chk("R7", 64'(rdata_oe), 64'd0);
    read_word(33, pat(33, 0), "R7");

    // host strobe ignored with sel_a_n high; host access never writes
    cur = "R8";
    start_read(12, 0, 0);
    idle(); sel_a_n = 1; start_host_n = 0; step_n = 0; addr = 6'd40; tick();
    idle(); tick();
    chk("R8", 64'(rdata), 64'(pat(13, 0)));
    idle(); start_host_n = 0; addr = 6'd20; wr_all_n = 0; wdata = pat(20, 5); tick();
    deselect();
    chk("R8", 64'(rdata), 64'(pat(20, 0)));
    read_word(20, pat(20, 0), "R8");

    // both strobes: host wins, read
    cur = "R9";
    idle(); start_host_n = 0; start_ctrl_n = 0; addr = 6'd44; wr_all_n = 0; wdata = pat(44, 2);
    tick();
    deselect();
    chk("R9", 64'(rdata_oe), 64'd1);
    chk("R9", 64'(rdata), 64'(pat(44, 0)));
    read_word(44, pat(44, 0), "R9");

    // async output enable
    cur = "R10";
    start_read(50, 1, 0);
    idle(); tick();
    oe_n = 1; #1;
    chk("R10", 64'(rdata_oe), 64'd0);
    oe_n = 0; #1;
    chk("R10", 64'(rdata_oe), 64'd1);
    deselect();

    // doze blocks a write and quiets the output
    cur = "R11";
    start_read(60, 0, 0);
    idle(); doze = 1; start_ctrl_n = 0; addr = 6'd61; wr_all_n = 0; wdata = pat(61, 4);
    tick();
    idle(); doze = 1; tick();
    chk("R11", 64'(rdata_oe), 64'd0);
    deselect();
    read_word(61, pat(61, 0), "R11");

    // constrained random traffic
    cur = "R2 R3 R4 R5 R7 R12 random";
    for (int i = 0; i < 3000; i++) begin
      idle();
      addr         = AW'($urandom);
      order_xor    = 1'($urandom);
      step_n       = 1'($urandom);
      start_host_n = ($urandom % 6) != 0;
      start_ctrl_n = ($urandom % 4) != 0;
      sel_a_n      = ($urandom % 8) == 0;
      sel_b        = ($urandom % 10) != 0;
      sel_c_n      = ($urandom % 12) == 0;
      wr_all_n     = ($urandom % 6) != 0;
      wr_lane_n    = ($urandom % 3) != 0;
      lane_sel_n   = 4'($urandom);
      doze         = ($urandom % 16) == 0;
      oe_n         = ($urandom % 8) == 0;
      wdata        = {4'($urandom), 32'($urandom)};
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule